// File: doc/BRIEF.md
# Crossroads Signal Sequencer

This block runs the lamps of a two-way intersection. The two approaches are called A and B. Each approach has a red, a yellow and a green lamp. The block takes a fast system clock and divides it into a one-second enable, which lasts a single clock cycle. A seconds timer counts these enables. A four-phase state machine steps forward each time the timer reaches the end of the current phase.

The machine gives green to A, then yellow to A, then green to B, then yellow to B, and then starts again. While one approach has green or yellow, the other approach shows red. Each red interval therefore lasts the other approach's green time plus its yellow time.

The green length, the yellow length and the prescaler width are parameters. A test can shrink them without changing the logic. One second is 2^PRESC_BITS system clock cycles.

Top module: `crossing_lights`

## Requirements
- R1: An active-high synchronous reset puts the block in the A-green/B-red phase and clears both the prescaler and the seconds timer. The first clock edge with reset low is counted as edge 1.
- R2: The phases follow a fixed order and then repeat: A green with B red, A yellow with B red, A red with B green, A red with B yellow.
- R3: Each green phase lasts GREEN_SEC seconds, that is GREEN_SEC * 2^PRESC_BITS clock cycles. After reset, A green holds through edge GREEN_SEC*2^PRESC_BITS - 1, and A yellow shows after edge GREEN_SEC*2^PRESC_BITS.
- R4: Each yellow phase lasts YELLOW_SEC seconds, that is YELLOW_SEC * 2^PRESC_BITS clock cycles.
- R5: Each red interval of a direction lasts (GREEN_SEC + YELLOW_SEC) * 2^PRESC_BITS cycles without a break.
- R6: In every cycle exactly one lamp per direction is lit, and the two green lamps are never lit together.
- R7: A reset asserted in the middle of any phase restarts the cycle from A green with a full green duration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| aRed | output | 1 | Red lamp, direction A |
| aYellow | output | 1 | Yellow lamp, direction A |
| aGreen | output | 1 | Green lamp, direction A |
| bRed | output | 1 | Red lamp, direction B |
| bYellow | output | 1 | Yellow lamp, direction B |
| bGreen | output | 1 | Green lamp, direction B |

## Verification
The assertions check four things on every cycle. Each direction shows exactly one lamp, and the two greens are never lit together. The phase holds unless the timer signals the end of the phase, and it moves to a new phase when it does. The timer never passes the longest phase, and the one-second enable never lasts more than one cycle.

Some behaviour can only be shown by the bench's scenarios, because it spans many cycles or depends on when reset arrives. These are the exact cycle at which each phase boundary falls, the length of a full red interval, and the restart after a reset that lands at a random point inside a phase.

// File: rtl/crossing_lights_pkg.sv
package crossing_lights_pkg;

  typedef enum logic [1:0] {
    PH_AGREEN  = 2'd0,
    PH_AYELLOW = 2'd1,
    PH_BGREEN  = 2'd2,
    PH_BYELLOW = 2'd3
  } phase_t;

  // strobes from control into datapath
  typedef struct packed {
    logic clrTimer;
    logic longPhase;
  } ctrlStrobe_t;

  // status from datapath back to control
  typedef struct packed {
    logic tick;
    logic timeout;
  } dpStatus_t;

  typedef struct packed {
    logic red;
    logic yellow;
    logic green;
  } lampSet_t;

endpackage

// File: rtl/crossing_lights_datapath.sv
module crossing_lights_datapath
  import crossing_lights_pkg::*;
#(
  parameter int PRESC_BITS = 22,
  parameter int GREEN_SEC  = 40,
  parameter int YELLOW_SEC = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  ctrlStrobe_t ctl,
  output dpStatus_t   stat
);

  localparam int MAX_SEC = (GREEN_SEC > YELLOW_SEC) ? GREEN_SEC : YELLOW_SEC;
  localparam int TW      = (MAX_SEC > 1) ? $clog2(MAX_SEC) : 1;
  localparam logic [TW-1:0] LONG_LAST  = TW'(GREEN_SEC - 1);
  localparam logic [TW-1:0] SHORT_LAST = TW'(YELLOW_SEC - 1);

  logic [PRESC_BITS-1:0] prescCnt;
  logic [TW-1:0]         secCnt;
  logic [TW-1:0]         lastSec;
  logic                  tick;

  // free-running prescaler; enable when it wraps
  always_ff @(posedge clk) begin
    if (rst) prescCnt <= '0;
    else     prescCnt <= prescCnt + 1'b1;
  end

  assign tick = &prescCnt;

  assign lastSec = ctl.longPhase ? LONG_LAST : SHORT_LAST;

  // seconds timer, cleared on each phase change
  always_ff @(posedge clk) begin
    if (rst)               secCnt <= '0;
    else if (ctl.clrTimer) secCnt <= '0;
    else if (tick)         secCnt <= secCnt + 1'b1;
  end

  assign stat.tick    = tick;
  assign stat.timeout = tick && (secCnt == lastSec);

  // R3
  timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
    secCnt <= LONG_LAST || secCnt <= SHORT_LAST);

  // R3
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/crossing_lights_control.sv
module crossing_lights_control
  import crossing_lights_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  dpStatus_t   stat,
  output ctrlStrobe_t ctl,
  output lampSet_t    lampA,
  output lampSet_t    lampB
);

  phase_t phase;
  phase_t phaseNext;

  always_comb begin
    case (phase)
      PH_AGREEN:  phaseNext = PH_AYELLOW;
      PH_AYELLOW: phaseNext = PH_BGREEN;
      PH_BGREEN:  phaseNext = PH_BYELLOW;
      PH_BYELLOW: phaseNext = PH_AGREEN;
      default:    phaseNext = PH_AGREEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)               phase <= PH_AGREEN;
    else if (stat.timeout) phase <= phaseNext;
  end

  assign ctl.clrTimer  = stat.timeout;
  assign ctl.longPhase = (phase == PH_AGREEN) || (phase == PH_BGREEN);

  always_comb begin
    lampA = '{red: 1'b0, yellow: 1'b0, green: 1'b0};
    lampB = '{red: 1'b0, yellow: 1'b0, green: 1'b0};
    case (phase)
      PH_AGREEN:  begin lampA.green  = 1'b1; lampB.red    = 1'b1; end
      PH_AYELLOW: begin lampA.yellow = 1'b1; lampB.red    = 1'b1; end
      PH_BGREEN:  begin lampA.red    = 1'b1; lampB.green  = 1'b1; end
      default:    begin lampA.red    = 1'b1; lampB.yellow = 1'b1; end
    endcase
  end

  // R1
  reset_phase_chk: assert property (@(posedge clk)
    rst |=> phase == PH_AGREEN);

  // R2
  hold_phase_chk: assert property (@(posedge clk) disable iff (rst)
    !stat.timeout |=> $stable(phase));

  // R2
  advance_phase_chk: assert property (@(posedge clk) disable iff (rst)
    stat.timeout |=> phase != $past(phase));

  // R2
  ag_to_ay_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_AGREEN && stat.timeout) |=> phase == PH_AYELLOW);

  // R6
  one_lamp_a_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({lampA.red, lampA.yellow, lampA.green}) == 1);

  // R6
  one_lamp_b_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({lampB.red, lampB.yellow, lampB.green}) == 1);

  // R6
  no_dual_green_chk: assert property (@(posedge clk) disable iff (rst)
    !(lampA.green && lampB.green));

endmodule

// File: rtl/crossing_lights.sv
module crossing_lights
  import crossing_lights_pkg::*;
#(
  parameter int PRESC_BITS = 22,
  parameter int GREEN_SEC  = 40,
  parameter int YELLOW_SEC = 5
) (
  input  logic clk,
  input  logic rst,
  output logic aRed,
  output logic aYellow,
  output logic aGreen,
  output logic bRed,
  output logic bYellow,
  output logic bGreen
);

  ctrlStrobe_t ctl;
  dpStatus_t   stat;
  lampSet_t    lampA;
  lampSet_t    lampB;

  crossing_lights_datapath #(
    .PRESC_BITS(PRESC_BITS),
    .GREEN_SEC (GREEN_SEC),
    .YELLOW_SEC(YELLOW_SEC)
  ) u_datapath (
    .clk (clk),
    .rst (rst),
    .ctl (ctl),
    .stat(stat)
  );

  crossing_lights_control u_control (
    .clk  (clk),
    .rst  (rst),
    .stat (stat),
    .ctl  (ctl),
    .lampA(lampA),
    .lampB(lampB)
  );

  assign aRed    = lampA.red;
  assign aYellow = lampA.yellow;
  assign aGreen  = lampA.green;
  assign bRed    = lampB.red;
  assign bYellow = lampB.yellow;
  assign bGreen  = lampB.green;

endmodule

// File: tb/crossing_lights_bench.sv
`timescale 1ns/1ps
module crossing_lights_bench;

  localparam int PB = 3;
  localparam int G  = 4;
  localparam int Y  = 2;
  localparam int P  = 1 << PB;
  localparam int CYC = 2 * (G + Y) * P;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic aRed, aYellow, aGreen, bRed, bYellow, bGreen;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  crossing_lights #(.PRESC_BITS(PB), .GREEN_SEC(G), .YELLOW_SEC(Y)) u_crossing_lights (
    .clk(clk), .rst(rst),
    .aRed(aRed), .aYellow(aYellow), .aGreen(aGreen),
    .bRed(bRed), .bYellow(bYellow), .bGreen(bGreen)
  );

  // expected lamps {aR,aY,aG,bR,bY,bG} n edges after reset release
  function automatic logic [5:0] expLamps(int n);
    int pos;
    pos = n % CYC;
    if (pos < G * P)             return 6'b001_100;
    else if (pos < (G + Y) * P)  return 6'b010_100;
    else if (pos < (2*G + Y)*P)  return 6'b100_001;
    else                         return 6'b100_010;
  endfunction

  function automatic logic [5:0] actLamps();
    return {aRed, aYellow, aGreen, bRed, bYellow, bGreen};
  endfunction

  task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: lamps act=%b exp=%b", tag, act, exp);
    end
  endtask

  initial begin
    #(5ns * 60000);
    bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int n;
    int rstLeft;
    int redRun;
    bit redValid;
    bit prevRed;
    bit midReset;
    logic [5:0] lamps;
    void'($urandom(32'h5eed_1234));
    n = 0; rstLeft = 0; redRun = 0; redValid = 1'b0; prevRed = 1'b0; midReset = 1'b0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", actLamps(), 6'b001_100);
    rst = 1'b0;

    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (rst) n = 0; else n = n + 1;
      @(negedge clk);
      lamps = actLamps();
      if (rst) begin
        check("R7", lamps, 6'b001_100);
        redValid = 1'b0;
      end else begin
        if (!midReset && n == G*P - 1)     check("R3", lamps, 6'b001_100);
        if (!midReset && n == G*P)         check("R3", lamps, 6'b010_100);
        if (!midReset && n == (G+Y)*P - 1) check("R4", lamps, 6'b010_100);
        if (!midReset && n == (G+Y)*P)     check("R4", lamps, 6'b100_001);
        check(midReset ? "R7" : "R2", lamps, expLamps(n));
      end
      // R6 invariant at the ports
      checks++;
      if (($countones(lamps[5:3]) != 1) || ($countones(lamps[2:0]) != 1) ||
          (lamps[3] && lamps[0])) begin
        bad++;
        $display("FAIL R6: lamps act=%b exp=one-per-direction", lamps);
      end
      // R5 red run length of direction A
      if (aRed && !prevRed) begin redRun = 1; redValid = !rst; end
      else if (aRed) redRun++;
      else if (prevRed && redValid) begin
        checks++;
        if (redRun != (G + Y) * P) begin
          bad++;
          $display("FAIL R5: red run act=%0d exp=%0d", redRun, (G + Y) * P);
        end
      end
      prevRed = aRed;
      // reset stimulus: random mid-phase resets after the first cycles
      if (rstLeft > 0) begin
        rstLeft--;
        rst = (rstLeft > 0);
      end else if (i > 2 * CYC && ($urandom % 300) == 0) begin
        rstLeft = 1 + ($urandom % 3);
        rst = 1'b1;
        midReset = 1'b1;
      end
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule